// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Validation

This block is the receive half of a serial port running in asynchronous mode. It runs on the receive clock and samples the serial input on each rising edge of that clock. The receive clock may run at 1, 16 or 64 times the bit rate. The receiver turns each incoming frame into a parallel character, right-aligned in a data register, and raises a ready flag for the host. It also reports, for each character, a parity error, a framing error and an overrun flag.

After a master reset the receiver ignores the line until it has seen a high level once. This stops a disconnected input that floats low from being read as a stream of characters. At 16x and 64x, every falling edge is checked again at the middle of the start bit, so a short noise pulse sends the receiver back to waiting instead of starting a character. The host clears the ready flag with a one-cycle read strobe. A separate enable bit holds the ready flag low and keeps the receiver idle.

Top module: `usart_rx_core`

## Requirements
- R1: While reset is low and on the first clock after it, `rx_rdy`, `par_err`, `frm_err`, `ovr_err` and `rx_data` are all zero.
- R2: After reset, no character is received until `rx_line` has been sampled high at least once. A line held low from reset produces no `rx_rdy`.
- R3: With `clk_factor` 2'b10 (16x) or 2'b11 (64x), a falling edge starts a character only if `rx_line` is still low 8 or 32 clocks later. Otherwise the receiver goes back to waiting for a falling edge and produces no character.
- R4: `clk_factor` 2'b00 or 2'b01 samples one bit per rising edge. 2'b10 samples the first data bit 24 clocks after the start edge and each later bit every 16 clocks. 2'b11 uses 96 clocks and every 64 clocks. A frame sent at the matching rate is received correctly at each factor.
- R5: `char_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, received least significant bit first. `rx_data` holds the character right-aligned, with the unused upper bits zero.
- R6: `rx_rdy` sets on the clock edge that samples the stop bit, and on no other event.
- R7: When `par_on` is 1, one parity bit follows the data. `par_odd`=0 selects even parity and 1 selects odd. A mismatch sets `par_err` for that character, and a correct bit clears it. When `par_on` is 0, `par_err` is 0.
- R8: `frm_err` is set for a character whose stop bit is sampled as 0, and cleared for a character whose stop bit is sampled as 1.
- R9: While `rx_en` is 0, `rx_rdy` is held at 0 and frames on the line are ignored.
- R10: A one-cycle `rd_strobe` clears `rx_rdy` and `ovr_err` on the next edge.
- R11: A character that completes while `rx_rdy` is still set replaces `rx_data` and sets `ovr_err`.
- R12: If `rd_strobe` falls on the same edge as a stop-bit sample, the new character wins. `rx_rdy` stays 1, `ovr_err` is 0, and `rx_data` holds the new character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive clock; all sampling is on its rising edge |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| rx_line | input | 1 | Serial data input, idle high |
| rx_en | input | 1 | Receiver enable |
| clk_factor | input | 2 | Clock-to-bit-rate ratio: 00/01 1x, 10 16x, 11 64x |
| char_len | input | 2 | Data bits per character minus five |
| par_on | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_strobe | input | 1 | Host read of the data register, one-cycle pulse |
| rx_data | output | 8 | Last received character, right-aligned |
| rx_rdy | output | 1 | A character is waiting for the host |
| par_err | output | 1 | Parity error of the last character |
| frm_err | output | 1 | Framing error of the last character |
| ovr_err | output | 1 | The last character overwrote an unread one |

## Verification
The host read and the completion of a new character can land on the same clock edge. One clears the ready flag and the overrun flag, while the other sets the ready flag and may set the overrun flag. The bench provokes this at the 1x factor, where the edge that samples the stop bit is known exactly: it raises the read strobe while the stop bit is on the line, with an earlier character still unread. It then expects the ready flag to stay set, the overrun flag to stay clear and the data register to hold the new character.

// File: rtl/usart_rx_core.sv
module usart_rx_core #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic [1:0]        clk_factor,
  input  logic [1:0]        char_len,
  input  logic              par_on,
  input  logic              par_odd,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err
);

  localparam int IDX_W = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_MID, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] sh;
  logic             run_par, bad_par, last_bit;

  logic [CNT_W-1:0] div_m1, half_m1;
  logic [IDX_W-1:0] nbits;

  assign div_m1  = (clk_factor == 2'b11) ? CNT_W'(63) :
                   (clk_factor == 2'b10) ? CNT_W'(15) : '0;
  assign half_m1 = (clk_factor == 2'b11) ? CNT_W'(31) :
                   (clk_factor == 2'b10) ? CNT_W'(7)  : '0;
  assign nbits   = IDX_W'(char_len) + IDX_W'(5);

  wire tick   = (cnt == '0);
  wire finish = (st == S_STOP) && tick && rx_en;

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_INIT;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      run_par  <= 1'b0;
      bad_par  <= 1'b0;
      last_bit <= 1'b0;
      rx_data  <= '0;
      rx_rdy   <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
    end else begin
      last_bit <= rx_line;
      if (rd_strobe) begin
        rx_rdy  <= 1'b0;
        ovr_err <= 1'b0;
      end
      case (st)
        S_INIT: if (rx_line) st <= S_IDLE;
        S_IDLE: begin
          if (last_bit && !rx_line) begin
            idx     <= '0;
            run_par <= 1'b0;
            bad_par <= 1'b0;
            if (div_m1 == '0) begin
              st  <= S_DATA;
              cnt <= '0;
            end else begin
              st  <= S_MID;
              cnt <= half_m1;
            end
          end
        end
        S_MID: begin
          if (tick) begin
            if (rx_line) st <= S_IDLE;
            else begin
              st  <= S_DATA;
              cnt <= div_m1;
            end
          end else cnt <= cnt - CNT_W'(1);
        end
        S_DATA: begin
          if (tick) begin
            sh      <= {rx_line, sh[DATA_W-1:1]};
            run_par <= run_par ^ rx_line;
            cnt     <= div_m1;
            idx     <= idx + IDX_W'(1);
            if (idx == nbits - IDX_W'(1)) st <= par_on ? S_PAR : S_STOP;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_PAR: begin
          if (tick) begin
            bad_par <= ((run_par ^ rx_line) != par_odd);
            cnt     <= div_m1;
            st      <= S_STOP;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_STOP: begin
          if (tick) begin
            rx_data <= sh >> (IDX_W'(DATA_W) - nbits);
            frm_err <= !rx_line;
            par_err <= par_on && bad_par;
            ovr_err <= rx_rdy && !rd_strobe;
            rx_rdy  <= 1'b1;
            st      <= S_IDLE;
          end else cnt <= cnt - CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
      if (!rx_en) begin
        rx_rdy <= 1'b0;
        if (st != S_INIT) st <= S_IDLE;
      end
    end
  end

  a_r9_rdy_low_when_off: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !rx_en |=> !rx_rdy);

  a_r2_no_start_before_idle_high: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (st == S_INIT && !rx_line) |=> (st == S_INIT));

  a_r3_spike_returns_to_wait: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (st == S_MID && tick && rx_line) |=> (st == S_IDLE));

  a_r6_rdy_only_from_stop: assert property (@(posedge rx_clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(finish));

  a_r10_read_clears: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (rd_strobe && !finish) |=> (!rx_rdy && !ovr_err));

  a_r11_overrun_needs_pending: assert property (@(posedge rx_clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(rx_rdy));

endmodule

// File: tb/usart_rx_core_tb.sv
module usart_rx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       en = 1'b1;
  logic [1:0] fac = 2'b01;
  logic [1:0] clen = 2'b11;
  logic       pon = 1'b0;
  logic       podd = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] data;
  logic       rdy, pe, fe, oe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  usart_rx_core dut_i (
    .rx_clk(clk), .rst_n(rst_n), .rx_line(line), .rx_en(en),
    .clk_factor(fac), .char_len(clen), .par_on(pon), .par_odd(podd),
    .rd_strobe(rd), .rx_data(data), .rx_rdy(rdy), .par_err(pe),
    .frm_err(fe), .ovr_err(oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_rate(input int d);
    fac = (d == 64) ? 2'b11 : (d == 16) ? 2'b10 : 2'b01;
  endtask

  task automatic frame(input logic [7:0] d, input int n, input bit pflip,
                       input bit stopv, input int dv, input bit rd_stop);
    logic pbit;
    pbit = ^(d & 8'((1 << n) - 1)) ^ podd ^ pflip;
    @(negedge clk); line = 1'b0;
    repeat (dv - 1) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); line = d[k];
      repeat (dv - 1) @(negedge clk);
    end
    if (pon) begin
      @(negedge clk); line = pbit;
      repeat (dv - 1) @(negedge clk);
    end
    @(negedge clk); line = stopv; rd = rd_stop;
    @(negedge clk); rd = 1'b0;
    repeat (dv - 1) @(negedge clk);
    line = 1'b1;
    repeat (dv + 2) @(negedge clk);
  endtask

  task automatic do_read;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rdy", rdy, 0); check("R1 data", data, 0);
    check("R1 errs", {pe, fe, oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdy after release", rdy, 0);
  endtask

  task automatic t_init;
    repeat (60) @(negedge clk);
    check("R2 low line gives no char", rdy, 0);
    line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_rates;
    set_rate(1); clen = 2'b11; pon = 0;
    frame(8'hA5, 8, 0, 1, 1, 0);
    check("R4 1x data", data, 8'hA5); check("R6 rdy set", rdy, 1);
    check("R8 no framing error", fe, 0); check("R7 no parity", pe, 0);
    do_read; check("R10 read clears rdy", rdy, 0);
    set_rate(16); clen = 2'b00;
    frame(8'hF6, 5, 0, 1, 16, 0);
    check("R5 5-bit right aligned", data, 8'h16); check("R4 16x rdy", rdy, 1);
    do_read;
    set_rate(64); clen = 2'b10; pon = 1; podd = 0;
    frame(8'h5A, 7, 0, 1, 64, 0);
    check("R4 64x 7-bit data", data, 8'h5A); check("R7 even parity ok", pe, 0);
    do_read;
  endtask

  task automatic t_errors;
    set_rate(16); clen = 2'b01; pon = 1; podd = 1;
    frame(8'h2B, 6, 1, 1, 16, 0);
    check("R7 odd parity error", pe, 1); check("R5 6-bit data", data, 8'h2B);
    do_read;
    frame(8'h13, 6, 0, 1, 16, 0);
    check("R7 odd parity ok clears", pe, 0);
    do_read;
    pon = 0; clen = 2'b11;
    frame(8'h3C, 8, 0, 0, 16, 0);
    check("R8 framing error", fe, 1); check("R8 data", data, 8'h3C);
    do_read;
    frame(8'hC3, 8, 0, 1, 16, 0);
    check("R8 framing cleared", fe, 0);
    do_read;
  endtask

  task automatic t_spike;
    set_rate(16); clen = 2'b11; pon = 0;
    @(negedge clk); line = 1'b0;
    repeat (4) @(negedge clk);
    line = 1'b1;
    repeat (300) @(negedge clk);
    check("R3 spike rejected 16x", rdy, 0);
    set_rate(64);
    @(negedge clk); line = 1'b0;
    repeat (20) @(negedge clk);
    line = 1'b1;
    repeat (800) @(negedge clk);
    check("R3 spike rejected 64x", rdy, 0);
    set_rate(16);
    frame(8'h81, 8, 0, 1, 16, 0);
    check("R3 receiver rearmed", data, 8'h81); check("R3 rdy", rdy, 1);
    do_read;
  endtask

  task automatic t_overrun;
    set_rate(1);
    frame(8'h11, 8, 0, 1, 1, 0);
    check("R11 no overrun first", oe, 0);
    frame(8'h22, 8, 0, 1, 1, 0);
    check("R11 overrun set", oe, 1); check("R11 data replaced", data, 8'h22);
    do_read;
    check("R10 read clears overrun", oe, 0); check("R10 rdy cleared", rdy, 0);
  endtask

  task automatic t_disable;
    set_rate(1);
    frame(8'h44, 8, 0, 1, 1, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R9 rdy held low", rdy, 0);
    frame(8'h99, 8, 0, 1, 1, 0);
    check("R9 frame ignored rdy", rdy, 0); check("R9 frame ignored data", data, 8'h44);
    en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_collide;
    set_rate(1);
    frame(8'h55, 8, 0, 1, 1, 0);
    frame(8'h6E, 8, 0, 1, 1, 1);
    check("R12 rdy kept", rdy, 1); check("R12 no overrun", oe, 0);
    check("R12 new data", data, 8'h6E);
    do_read;
  endtask

  initial begin
    t_reset;
    t_init;
    t_rates;
    t_errors;
    t_spike;
    t_overrun;
    t_disable;
    t_collide;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule